// File: doc/BRIEF.md
# Ethernet Fast-Path Packet Classifier

This block watches the first six 32-bit lines of every received Ethernet frame as they stream past. It compares the destination and source MAC addresses, the ethertype, a flags word and a sequence number with values that software has written into a small set of write-only registers. When all of them agree, the frame is tagged fast path and the expected sequence number steps forward by one, ready for the next frame. When any field differs, or the frame ends before its header is complete, the frame is tagged slow path so that the buffer status logic can record it and hand the frame to firmware.

The verdict appears as a one-cycle strobe with a slow-path flag beside it. The current expected sequence number is always visible on its own output. Lines that follow the header are ignored until the next frame starts.

Top module: `eth_fpc_classifier`

## Requirements
- R1: After reset, verdict_valid is 0, exp_seq is 0 and every programmed match value is 0, so a frame whose six header lines are all zero is classified fast path.
- R2: Header lines are numbered from the line marked ln_first. Line 0 carries destination bytes 0..3, line 1 destination bytes 4..5 then source bytes 0..1, line 2 source bytes 2..5, line 3 the ethertype in bits 31:16, line 4 the flags and line 5 the sequence number.
- R3: When all six header lines match, verdict_valid is 1 with verdict_slow 0 in the cycle after line 5 is accepted, and in that same cycle exp_seq has advanced by one, modulo 2^32.
- R4: A mismatch in any bit that is compared on any header line gives verdict_slow 1 in the verdict cycle, and exp_seq keeps its value.
- R5: Only bits 31:16 of line 3 are compared with bits 31:16 of the ethertype register. Bits 15:0 of both are ignored.
- R6: A frame whose ln_last line arrives before line 5 gets a slow-path verdict in the cycle after that line, and exp_seq is unchanged.
- R7: Each header produces exactly one verdict. Lines after line 5 and lines outside a frame give no further strobe and do not change exp_seq.
- R8: A line marked ln_first always restarts the header at line 0. A partial header that is cut off this way gets no verdict.
- R9: Register map on cfg_addr: 0 flags, 1 destination bytes 0..3, 2 destination bytes 4..5 and source bytes 0..1, 3 source bytes 2..5, 4 ethertype (bits 31:16), 5 expected sequence. Writes to 6 and 7 have no effect.
- R10: A write to address 5 loads exp_seq on the next cycle. If it falls in the same cycle as a fast-path increment, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | LINE_W | Register write data |
| ln_valid | input | 1 | A frame line is presented this cycle |
| ln_first | input | 1 | Line is the first of a frame |
| ln_last | input | 1 | Line is the last of a frame |
| ln_data | input | LINE_W | Line contents |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_slow | output | 1 | 1 = slow path, 0 = fast path (meaningful with the strobe) |
| exp_seq | output | LINE_W | Current expected sequence number |

## Verification
The bench builds the block with the default LINE_W of 32, which is the width at which the documented header layout and register packing apply. At this width a sequence load of all ones followed by a matching frame reaches the modulo-2^32 wrap of exp_seq. It also lets every frame length from a single line up to well past the six-line header be tried, including frames that end exactly on line 5.

// File: rtl/eth_fpc_pkg.sv
package eth_fpc_pkg;
    localparam int HDR_LINES  = 6;
    localparam int IDX_W      = $clog2(HDR_LINES);
    localparam int CFG_AW     = 3;
    localparam int ETYPE_LINE = 3;

    // register select codes
    localparam logic [CFG_AW-1:0] RG_FLAGS = 3'd0;
    localparam logic [CFG_AW-1:0] RG_DSTA  = 3'd1;
    localparam logic [CFG_AW-1:0] RG_MIXED = 3'd2;
    localparam logic [CFG_AW-1:0] RG_SRCB  = 3'd3;
    localparam logic [CFG_AW-1:0] RG_ETYPE = 3'd4;
    localparam logic [CFG_AW-1:0] RG_SEQ   = 3'd5;

    // which register supplies the expected value of each header line
    function automatic int line_src(input int line);
        case (line)
            0:       return 1;
            1:       return 2;
            2:       return 3;
            3:       return 4;
            4:       return 0;
            default: return 5;
        endcase
    endfunction

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             busy;
        logic             miss;
        logic             vld;
        logic             slow;
    } cls_state_t;
endpackage

// File: rtl/eth_fpc_cfg.sv
module eth_fpc_cfg
    import eth_fpc_pkg::*;
#(
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [LINE_W-1:0] wdata,
    input  logic              seq_inc,
    output logic [LINE_W-1:0] exp_line [HDR_LINES]
);
    logic [LINE_W-1:0] reg_d [HDR_LINES];
    logic [LINE_W-1:0] reg_q [HDR_LINES];

    always_comb begin
        for (int k = 0; k < HDR_LINES; k++) begin
            reg_d[k] = reg_q[k];
            if (we && addr == CFG_AW'(k)) begin
                reg_d[k] = wdata;
            end
        end
        // sequence: software load wins over the match increment
        if (!(we && addr == RG_SEQ) && seq_inc) begin
            reg_d[int'(RG_SEQ)] = reg_q[int'(RG_SEQ)] + LINE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < HDR_LINES; k++) begin
            if (!rst_n) reg_q[k] <= '0;
            else        reg_q[k] <= reg_d[k];
        end
    end

    for (genvar g = 0; g < HDR_LINES; g++) begin : g_map
        assign exp_line[g] = reg_q[line_src(g)];
    end
endmodule

// File: rtl/eth_fpc_match.sv
module eth_fpc_match
    import eth_fpc_pkg::*;
#(
    parameter int LINE_W = 32
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [LINE_W-1:0] data,
    input  logic [LINE_W-1:0] exp_line [HDR_LINES],
    output logic              hit
);
    localparam int HALF = LINE_W / 2;
    localparam logic [LINE_W-1:0] ETYPE_MASK = {{(LINE_W-HALF){1'b1}}, {HALF{1'b0}}};

    always_comb begin
        hit = 1'b1;
        for (int i = 0; i < HDR_LINES; i++) begin
            if (idx == IDX_W'(i)) begin
                if (i == ETYPE_LINE) hit = ((data ^ exp_line[i]) & ETYPE_MASK) == '0;
                else                 hit = (data == exp_line[i]);
            end
        end
    end
endmodule

// File: rtl/eth_fpc_classifier.sv
module eth_fpc_classifier
    import eth_fpc_pkg::*;
#(
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [LINE_W-1:0] cfg_wdata,
    input  logic              ln_valid,
    input  logic              ln_first,
    input  logic              ln_last,
    input  logic [LINE_W-1:0] ln_data,
    output logic              verdict_valid,
    output logic              verdict_slow,
    output logic [LINE_W-1:0] exp_seq
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_LINES - 1);

    cls_state_t        s_d, s_q;
    logic [IDX_W-1:0]  cur_idx;
    logic              hit;
    logic              seq_inc;
    logic [LINE_W-1:0] exp_line [HDR_LINES];

    eth_fpc_cfg #(.LINE_W(LINE_W)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .seq_inc  (seq_inc),
        .exp_line (exp_line)
    );

    eth_fpc_match #(.LINE_W(LINE_W)) i_match (
        .idx      (cur_idx),
        .data     (ln_data),
        .exp_line (exp_line),
        .hit      (hit)
    );

    assign cur_idx = ln_first ? '0 : s_q.idx;

    always_comb begin
        logic miss_now;
        s_d      = s_q;
        s_d.vld  = 1'b0;
        s_d.slow = 1'b0;
        seq_inc  = 1'b0;
        miss_now = ((s_q.miss && !ln_first) || !hit);
        if (ln_valid && (ln_first || s_q.busy)) begin
            if (cur_idx == LAST_IDX) begin
                s_d.vld  = 1'b1;
                s_d.slow = miss_now;
                seq_inc  = !miss_now;
                s_d.busy = 1'b0;
                s_d.idx  = '0;
                s_d.miss = 1'b0;
            end else if (ln_last) begin
                s_d.vld  = 1'b1;
                s_d.slow = 1'b1;
                s_d.busy = 1'b0;
                s_d.idx  = '0;
                s_d.miss = 1'b0;
            end else begin
                s_d.busy = 1'b1;
                s_d.idx  = cur_idx + IDX_W'(1);
                s_d.miss = miss_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign verdict_valid = s_q.vld;
    assign verdict_slow  = s_q.slow;
    assign exp_seq       = exp_line[HDR_LINES-1];
endmodule

// File: rtl/eth_fpc_chk.sv
module eth_fpc_chk
    import eth_fpc_pkg::*;
#(
    parameter int LINE_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [LINE_W-1:0] cfg_wdata,
    input logic              ln_valid,
    input logic              verdict_valid,
    input logic              verdict_slow,
    input logic [LINE_W-1:0] exp_seq
);
    logic seq_wr;
    assign seq_wr = cfg_we && cfg_addr == RG_SEQ;

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && !verdict_slow && !$past(seq_wr)) |-> exp_seq == $past(exp_seq) + LINE_W'(1)); // R3
    AST_SEQ_HOLD_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && verdict_slow && !$past(seq_wr)) |-> $stable(exp_seq)); // R4
    AST_SEQ_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!verdict_valid && !$past(seq_wr)) |-> $stable(exp_seq)); // R7
    AST_SEQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        seq_wr |=> exp_seq == $past(cfg_wdata)); // R10
    AST_VERDICT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> $past(ln_valid)); // R7
    AST_SLOW_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_slow |-> verdict_valid); // R4
endmodule

bind eth_fpc_classifier eth_fpc_chk #(.LINE_W(LINE_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .ln_valid      (ln_valid),
    .verdict_valid (verdict_valid),
    .verdict_slow  (verdict_slow),
    .exp_seq       (exp_seq)
);

// File: tb/test_eth_fpc_classifier.sv
`timescale 1ns/1ps
module test_eth_fpc_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ln_valid = 1'b0;
    logic        ln_first = 1'b0;
    logic        ln_last = 1'b0;
    logic [31:0] ln_data = '0;
    logic        verdict_valid;
    logic        verdict_slow;
    logic [31:0] exp_seq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] m_cfg [5];
    logic [31:0] m_seq;
    logic [31:0] hdr [6];

    always #2.5 clk = ~clk;

    eth_fpc_classifier #(.LINE_W(32)) i_eth_fpc_classifier (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ln_valid(ln_valid), .ln_first(ln_first),
        .ln_last(ln_last), .ln_data(ln_data), .verdict_valid(verdict_valid),
        .verdict_slow(verdict_slow), .exp_seq(exp_seq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // expected value of each header line per R2/R9
    function automatic logic [31:0] exp_of(input int line);
        case (line)
            0: return m_cfg[1];
            1: return m_cfg[2];
            2: return m_cfg[3];
            3: return m_cfg[4];
            4: return m_cfg[0];
            default: return m_seq;
        endcase
    endfunction

    function automatic bit hdr_miss();
        bit m = 0;
        for (int i = 0; i < 6; i++) begin
            if (i == 3) m |= (hdr[i][31:16] != exp_of(i)[31:16]);
            else        m |= (hdr[i] != exp_of(i));
        end
        return m;
    endfunction

    function automatic void hdr_match();
        for (int i = 0; i < 6; i++) hdr[i] = exp_of(i);
        hdr[3][15:0] = 16'($urandom);
    endfunction

    task automatic wr_cfg(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 3'd5) m_cfg[a] = d;
        else if (a == 3'd5) m_seq = d;
    endtask

    // n lines; with_last marks the final one; optional seq write alongside line 5
    task automatic run_frame(input int n, input bit with_last, input bit seq_wr,
                             input logic [31:0] seq_val, input string tag);
        bit slow_e = hdr_miss();
        for (int i = 0; i < n; i++) begin
            bit last = with_last && (i == n - 1);
            bit v_e  = (i == 5) || (last && i < 5);
            bit s_e  = (i < 5) ? 1'b1 : slow_e;
            ln_valid = 1'b1; ln_first = (i == 0); ln_last = last;
            ln_data  = (i < 6) ? hdr[i] : $urandom;
            if (seq_wr && i == 5) begin
                cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = seq_val;
            end
            @(negedge clk);
            ln_valid = 1'b0; ln_first = 1'b0; ln_last = 1'b0; cfg_we = 1'b0;
            chk(verdict_valid == v_e, {tag, " R7 strobe"}, 32'(verdict_valid), 32'(v_e));
            if (v_e) begin
                chk(verdict_slow == s_e, {tag, " R3/R4/R6 verdict"}, 32'(verdict_slow), 32'(s_e));
                if (seq_wr && i == 5) m_seq = seq_val;
                else if (!s_e) m_seq = m_seq + 1;
            end
            chk(exp_seq == m_seq, {tag, " R3/R10 exp_seq"}, exp_seq, m_seq);
        end
    endtask

    initial begin
        for (int i = 0; i < 5; i++) m_cfg[i] = '0;
        m_seq = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(verdict_valid == 1'b0, "R1 valid after reset", 32'(verdict_valid), 0);
        chk(exp_seq == 32'd0, "R1 seq after reset", exp_seq, 0);
        for (int i = 0; i < 6; i++) hdr[i] = '0;
        run_frame(6, 1, 0, 0, "R1 zero frame");

        // R9 program all fields, R2 layout
        wr_cfg(3'd1, 32'h0011_2233);
        wr_cfg(3'd2, 32'h4455_A0A1);
        wr_cfg(3'd3, 32'hA2A3_A4A5);
        wr_cfg(3'd4, 32'h0800_1234);
        wr_cfg(3'd0, 32'hCAFE_0001);
        wr_cfg(3'd5, 32'h0000_0100);
        chk(exp_seq == 32'h100, "R10 seq load", exp_seq, 32'h100);
        hdr_match();
        run_frame(6, 1, 0, 0, "R2 R3 fast");
        hdr_match();
        run_frame(6, 1, 0, 0, "R3 fast again");

        // R4 single-field mismatch on every line
        for (int j = 0; j < 6; j++) begin
            hdr_match();
            hdr[j] = hdr[j] ^ (32'h1 << ((j == 3) ? 16 + j : j * 5));
            run_frame(6, 1, 0, 0, "R4 field miss");
        end
        // R5 ethertype pad differs
        hdr_match();
        hdr[3][15:0] = ~m_cfg[4][15:0];
        run_frame(6, 1, 0, 0, "R5 pad ignored");

        // R6 short frames
        for (int n = 1; n <= 5; n++) begin
            hdr_match();
            run_frame(n, 1, 0, 0, "R6 short");
        end
        // R7 long frame, then stray lines outside a frame
        hdr_match();
        run_frame(11, 1, 0, 0, "R7 long");
        for (int k = 0; k < 4; k++) begin
            ln_valid = 1'b1; ln_data = $urandom;
            @(negedge clk);
            ln_valid = 1'b0;
            chk(verdict_valid == 1'b0, "R7 stray line", 32'(verdict_valid), 0);
        end
        // R8 partial header cut off by a new first line
        hdr_match();
        run_frame(3, 0, 0, 0, "R8 partial");
        hdr_match();
        run_frame(6, 1, 0, 0, "R8 restart");

        // R9 unused addresses
        wr_cfg(3'd6, 32'hFFFF_FFFF);
        wr_cfg(3'd7, 32'h1234_5678);
        hdr_match();
        run_frame(6, 1, 0, 0, "R9 unused addr");

        // R10 load vs increment collision, and wrap
        hdr_match();
        run_frame(6, 1, 1, 32'h5555_0000, "R10 collide");
        wr_cfg(3'd5, 32'hFFFF_FFFF);
        hdr_match();
        run_frame(6, 1, 0, 0, "R3 wrap");
        chk(exp_seq == 32'h0, "R3 wrap value", exp_seq, 0);

        // random mix
        for (int f = 0; f < 300; f++) begin
            int n;
            if ($urandom_range(9) == 0) wr_cfg(3'($urandom_range(4)), $urandom);
            hdr_match();
            if ($urandom_range(2) == 0) begin
                int j = $urandom_range(5);
                hdr[j] = hdr[j] ^ (32'h1 << $urandom_range(31));
            end
            n = ($urandom_range(9) < 7) ? $urandom_range(12, 6) : $urandom_range(5, 1);
            run_frame(n, 1, 0, 0, "R2 R3 R4 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule